// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A clocked single-port memory of 32-bit words. Every address and control input is captured on the rising clock edge. Reads return data through a two-stage pipeline. The first edge registers the address, and the second edge loads the word into an output register. The output register drives the bus, qualified by a tri-state enable. Writes are self-timed: the word, or the selected byte lanes of it, is stored on the edge that accepts it.

A cycle that carries either of two start strobes, with the device selected, loads an external address and opens a four-beat burst. On each later cycle without a strobe, the device accesses the next address of the burst when the advance input is high, or repeats the current address when it is low. A two-bit counter replaces the low address bits. It runs in linear or interleaved order, chosen by a mode input, and it wraps inside the aligned four-word group. Three chip enables gate the device. An asynchronous output enable and a sleep input release the bus at once. Sleep also freezes the device without losing the array contents. The array depth is set by an address-width parameter (16 bits for the full 64K-word part).

Top module: `pipe_burst_sram`

## Requirements
- R1: While `rstN` is low and after its release with no accepted read, `dataOutEn` is 0 and no burst is open.
- R2: A read accepted at edge k drives `dataOutEn`=1 with the stored word on `dataOut` from edge k+1 until edge k+2 (given `outEn`=1 and `sleep`=0), and the bus is undriven in every cycle that carries no such data.
- R3: A write takes effect on its accepting edge. `fullWrite`=1 stores all 32 bits whatever `byteEn` holds. Otherwise `byteWrite`=1 stores lane i (bits 8i+7..8i) for each `byteEn[i]`=1 and keeps the other lanes. With `fullWrite`=0 and no lane selected, the access is a read.
- R4: With `interleave`=0, beat n of a burst starting at address s accesses the upper address bits of s with low bits (s[1:0]+n) mod 4. After the fourth beat it wraps within the same four-word group.
- R5: With `interleave`=1, the low bits of beat n are s[1:0] XOR n.
- R6: On a cycle with no strobe and `advance`=0 inside an open burst, the same address as in the previous beat is accessed again.
- R7: `startA` and `startB` each start a burst at `addrIn` (beat 0) when the device is selected, and each overrides any open burst.
- R8: The device is selected only when `selA`=1, `selB`=1 and `selCN`=0. A strobe while unselected performs no access, closes the burst, and leaves the bus undriven from the edge after it, so a read accepted one edge earlier still drives for one cycle.
- R9: `outEn` acts without a clock edge. When it is low, `dataOutEn` is 0. Raising it within a data cycle drives that cycle's word at once.
- R10: While `sleep`=1, `dataOutEn` is 0 at once, and all inputs are ignored: no write, and the burst position stays frozen. Array contents are kept, and the first edge with `sleep`=0 resumes operation from the frozen burst position.
- R11: A cycle with no strobe and no open burst performs no access, even with write controls active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of control and pipeline state |
| addrIn | input | ADDR_W | External word address, loaded by a start strobe |
| startA | input | 1 | Burst start strobe, first source |
| startB | input | 1 | Burst start strobe, second source |
| advance | input | 1 | Step the burst counter on a non-strobe cycle |
| interleave | input | 1 | 1 selects interleaved burst order, 0 linear |
| selA | input | 1 | Chip enable, active high |
| selB | input | 1 | Chip enable, active high |
| selCN | input | 1 | Chip enable, active low |
| fullWrite | input | 1 | Write all 32 bits |
| byteWrite | input | 1 | Enable per-lane writes selected by byteEn |
| byteEn | input | 4 | Byte lane selects, bit i for bits 8i+7..8i |
| dataIn | input | 32 | Write data |
| outEn | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down request |
| dataOut | output | 32 | Output register contents |
| dataOutEn | output | 1 | Tri-state drive enable for dataOut |

## Verification
A read accepted at edge k is due at edge k+1. The bench therefore books each read into a queue with a due cycle two counts beyond the cycle counter at the time it drives the request. It compares at the falling edge after the due edge, once the output register has settled. Writes are due on their accepting edge, so they only update the bench's shadow array, and later reads check them. In every cycle where no item falls due, the monitor requires an undriven bus. This check covers the one-cycle release after deselect and the idle cycles. The asynchronous effects of `outEn` and `sleep` are checked a fraction of a cycle after the input changes, before the next rising edge.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANE_N = WORD_W / LANE_W;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic              doRead;
    logic              doWrite;
    logic [LANE_N-1:0] laneMask;
    logic              flush;
  } strobe_t;
endpackage

// File: rtl/burst_order.sv
`timescale 1ns/1ps
module burst_order
  import sram_pkg::*;
(
  input  logic [BEAT_W-1:0] startLow,
  input  logic [BEAT_W-1:0] beat,
  input  logic              interleave,
  output logic [BEAT_W-1:0] lowAddr
);
  always_comb begin
    if (interleave) lowAddr = startLow ^ beat;
    else            lowAddr = startLow + beat;
  end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              startA,
  input  logic              startB,
  input  logic              advance,
  input  logic              interleave,
  input  logic              selA,
  input  logic              selB,
  input  logic              selCN,
  input  logic              fullWrite,
  input  logic              byteWrite,
  input  logic [LANE_N-1:0] byteEn,
  input  logic              sleep,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] accAddr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              active;
  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] nextBeat;
  logic [BEAT_W-1:0] seqLow;
  logic              strobe;
  logic              chipOn;
  logic              access;
  logic [LANE_N-1:0] wrMask;

  assign strobe   = startA | startB;
  assign chipOn   = selA & selB & ~selCN;
  assign nextBeat = advance ? beatCnt + 1'b1 : beatCnt;

  burst_order u_order (
    .startLow  (baseAddr[BEAT_W-1:0]),
    .beat      (nextBeat),
    .interleave(interleave),
    .lowAddr   (seqLow)
  );

  always_comb begin
    if (fullWrite)      wrMask = '1;
    else if (byteWrite) wrMask = byteEn;
    else                wrMask = '0;
  end

  assign access  = !sleep && (strobe ? chipOn : active);
  assign accAddr = strobe ? addrIn : {baseAddr[ADDR_W-1 -: HI_W], seqLow};

  always_comb begin
    stb.doWrite  = access && (|wrMask);
    stb.doRead   = access && !(|wrMask);
    stb.laneMask = wrMask;
    stb.flush    = sleep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (!sleep) begin
      if (strobe) begin
        active <= chipOn;
        if (chipOn) begin
          baseAddr <= addrIn;
          beatCnt  <= '0;
        end
      end else if (active) begin
        beatCnt <= nextBeat;
      end
    end
  end

  // R4
  burst_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !sleep && !strobe && advance) |=> (beatCnt == $past(beatCnt) + 2'd1));

  // R6
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !sleep && !strobe && !advance) |=> ($stable(beatCnt) && $stable(baseAddr)));

  // R10
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(active) && $stable(beatCnt) && $stable(baseAddr)));

  // R8
  deselect_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && strobe && !(selA && selB && !selCN)) |=> !active);

  // R11
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !strobe) |-> (!stb.doRead && !stb.doWrite));
endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEn,
  input  logic              sleep,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] merged;
  logic              rdValid1;
  logic [ADDR_W-1:0] rdAddr1;
  logic              outValid;
  logic [WORD_W-1:0] outWord;

  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = stb.laneMask[g] ? dataIn[g*LANE_W +: LANE_W]
                                                         : mem[accAddr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (stb.doWrite) mem[accAddr] <= merged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid1 <= 1'b0;
      rdAddr1  <= '0;
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      rdValid1 <= stb.doRead;
      if (stb.doRead) rdAddr1 <= accAddr;
      outValid <= rdValid1 && !stb.flush;
      if (rdValid1) outWord <= mem[rdAddr1];
    end
  end

  assign dataOut   = outWord;
  assign dataOutEn = outValid && outEn && !sleep;

  // R2
  read_pipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid1 && !stb.flush) |=> outValid);

  // R2
  out_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rdValid1));

  // R3
  write_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWrite |=> !rdValid1);
endmodule

// File: rtl/pipe_burst_sram.sv
`timescale 1ns/1ps
module pipe_burst_sram #(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              startA,
  input  logic              startB,
  input  logic              advance,
  input  logic              interleave,
  input  logic              selA,
  input  logic              selB,
  input  logic              selCN,
  input  logic              fullWrite,
  input  logic              byteWrite,
  input  logic [3:0]        byteEn,
  input  logic [31:0]       dataIn,
  input  logic              outEn,
  input  logic              sleep,
  output logic [31:0]       dataOut,
  output logic              dataOutEn
);
  sram_pkg::strobe_t stb;
  logic [ADDR_W-1:0] accAddr;

  sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrIn),
    .startA    (startA),
    .startB    (startB),
    .advance   (advance),
    .interleave(interleave),
    .selA      (selA),
    .selB      (selB),
    .selCN     (selCN),
    .fullWrite (fullWrite),
    .byteWrite (byteWrite),
    .byteEn    (byteEn),
    .sleep     (sleep),
    .stb       (stb),
    .accAddr   (accAddr)
  );

  sram_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .accAddr  (accAddr),
    .dataIn   (dataIn),
    .outEn    (outEn),
    .sleep    (sleep),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn)
  );
endmodule

// File: tb/pipe_burst_sram_tb.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          startA = 0, startB = 0, advance = 0, interleave = 0;
  logic          selA = 1, selB = 1, selCN = 0;
  logic          fullWrite = 0, byteWrite = 0;
  logic [3:0]    byteEn = '0;
  logic [31:0]   dataIn = '0;
  logic          outEn = 1, sleep = 0;
  logic [31:0]   dataOut;
  logic          dataOutEn;

  always #2.5 clk = ~clk;

  pipe_burst_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .startA(startA), .startB(startB),
    .advance(advance), .interleave(interleave), .selA(selA), .selB(selB),
    .selCN(selCN), .fullWrite(fullWrite), .byteWrite(byteWrite), .byteEn(byteEn),
    .dataIn(dataIn), .outEn(outEn), .sleep(sleep), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  typedef struct {
    int          due;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t       q[$];
  logic [31:0] shadow [0:(1<<AW)-1];
  int          cyc = 0;
  int          errors = 0;
  int          checks = 0;
  string       curTag = "R1";
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops each read at its due cycle, otherwise the bus must be idle.
  always @(negedge clk) begin
    item_t it;
    if (rstN && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        it = q.pop_front();
        if (outEn && !sleep) begin
          check(dataOutEn === 1'b1, it.tag, {31'd0, dataOutEn}, 32'd1, "drive");
          check(dataOut === it.val, it.tag, dataOut, it.val, "data");
        end else begin
          check(dataOutEn === 1'b0, it.tag, {31'd0, dataOutEn}, 32'd0, "released");
        end
      end else begin
        check(dataOutEn === 1'b0, curTag, {31'd0, dataOutEn}, 32'd0, "idle bus");
      end
    end
  end

  function automatic logic [AW-1:0] linA(input logic [AW-1:0] b, input int n);
    logic [1:0] lo;
    lo = b[1:0] + n[1:0];
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [AW-1:0] intA(input logic [AW-1:0] b, input int n);
    logic [1:0] lo;
    lo = b[1:0] ^ n[1:0];
    return {b[AW-1:2], lo};
  endfunction

  // Entered and left at falling edge + 1 ns; inputs already set by the caller.
  task automatic tick(input bit acc, input logic [AW-1:0] ea, input string tag);
    logic [3:0] m;
    m = fullWrite ? 4'hF : (byteWrite ? byteEn : 4'h0);
    curTag = tag;
    if (acc && !sleep) begin
      if (m != 4'h0) begin
        for (int i = 0; i < 4; i++)
          if (m[i]) shadow[ea][i*8 +: 8] = dataIn[i*8 +: 8];
      end else begin
        q.push_back('{cyc + 2, shadow[ea], tag});
      end
    end
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic op(input bit sa, input bit sb, input bit adv, input logic [AW-1:0] ad,
                    input bit fw, input bit bw, input logic [3:0] be, input logic [31:0] d,
                    input bit acc, input logic [AW-1:0] ea, input string tag);
    startA = sa; startB = sb; advance = adv; addrIn = ad;
    fullWrite = fw; byteWrite = bw; byteEn = be; dataIn = d;
    tick(acc, ea, tag);
  endtask

  // Unselected strobe carrying a write to 0x10: no access, burst closed.
  task automatic desel(input bit viaLowEnable);
    startA = 1; startB = 0; advance = 0; addrIn = 8'h10;
    fullWrite = 1; byteWrite = 0; dataIn = 32'hBAD0_BAD0;
    if (viaLowEnable) selCN = 1; else selB = 0;
    tick(0, '0, "R8");
    selCN = 0; selB = 1; startA = 0; fullWrite = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dataOutEn === 1'b0, "R1", {31'd0, dataOutEn}, 32'd0, "drive in reset");
    #1;
    rstN = 1;
    @(negedge clk);
    #1;
    check(dataOutEn === 1'b0, "R1", {31'd0, dataOutEn}, 32'd0, "drive after reset");
    // R11: nothing open after reset, write controls ignored
    op(0, 0, 1, 8'h12, 1, 0, 4'h0, 32'hFFFF_0000, 0, '0, "R11");

    // R4 R3: linear write burst from 0x12
    op(1, 0, 0, 8'h12, 1, 0, 4'h0, 32'hC0DE_0000, 1, linA(8'h12, 0), "R4");
    for (int n = 1; n < 4; n++)
      op(0, 0, 1, '0, 1, 0, 4'h0, 32'hC0DE_0000 | n, 1, linA(8'h12, n), "R4");

    // R7: second strobe overrides the open burst; R4 linear read with wrap
    op(0, 1, 0, 8'h11, 0, 0, 4'h0, '0, 1, linA(8'h11, 0), "R7");
    for (int n = 1; n < 5; n++)
      op(0, 0, 1, '0, 0, 0, 4'h0, '0, 1, linA(8'h11, n), "R4");
    desel(0);

    // R5: interleaved order
    interleave = 1;
    op(1, 0, 0, 8'h11, 0, 0, 4'h0, '0, 1, intA(8'h11, 0), "R5");
    for (int n = 1; n < 4; n++)
      op(0, 0, 1, '0, 0, 0, 4'h0, '0, 1, intA(8'h11, n), "R5");
    op(0, 1, 0, 8'h13, 0, 0, 4'h0, '0, 1, intA(8'h13, 0), "R5");
    for (int n = 1; n < 5; n++)
      op(0, 0, 1, '0, 0, 0, 4'h0, '0, 1, intA(8'h13, n), "R5");
    desel(1);
    interleave = 0;

    // R6: advance low repeats the word
    op(1, 0, 0, 8'h10, 0, 0, 4'h0, '0, 1, 8'h10, "R6");
    op(0, 0, 0, '0, 0, 0, 4'h0, '0, 1, 8'h10, "R6");
    op(0, 0, 1, '0, 0, 0, 4'h0, '0, 1, linA(8'h10, 1), "R6");
    op(0, 0, 0, '0, 0, 0, 4'h0, '0, 1, linA(8'h10, 1), "R6");
    op(0, 0, 1, '0, 0, 0, 4'h0, '0, 1, linA(8'h10, 2), "R6");
    desel(0);

    // R3: lane writes and full-word override
    op(1, 0, 0, 8'h20, 1, 0, 4'h0, 32'hAAAA_AAAA, 1, 8'h20, "R3");
    op(0, 0, 0, '0, 0, 1, 4'b0101, 32'h1122_3344, 1, 8'h20, "R3");
    op(0, 0, 0, '0, 0, 0, 4'h0, '0, 1, 8'h20, "R3");
    op(0, 0, 0, '0, 1, 1, 4'b0001, 32'h5566_7788, 1, 8'h20, "R3");
    op(0, 0, 0, '0, 0, 1, 4'b1000, 32'h9900_0000, 1, 8'h20, "R3");
    op(0, 0, 0, '0, 0, 1, 4'b0000, 32'hFFFF_FFFF, 1, 8'h20, "R3");
    desel(0);
    op(0, 1, 0, 8'h20, 0, 0, 4'h0, '0, 1, 8'h20, "R3");

    // R8: one-cycle release after deselect, then R11 no access while closed
    op(1, 0, 0, 8'h11, 0, 0, 4'h0, '0, 1, 8'h11, "R8");
    desel(1);
    op(0, 0, 1, '0, 1, 0, 4'h0, 32'hDEAD_DEAD, 0, '0, "R11");
    op(0, 0, 1, '0, 1, 0, 4'h0, 32'hDEAD_DEAD, 0, '0, "R11");
    op(1, 0, 0, 8'h12, 0, 0, 4'h0, '0, 1, 8'h12, "R11");
    op(1, 0, 0, 8'h10, 0, 0, 4'h0, '0, 1, 8'h10, "R8");
    desel(0);

    // R9: asynchronous output enable
    outEn = 0;
    op(1, 0, 0, 8'h13, 0, 0, 4'h0, '0, 1, 8'h13, "R9");
    op(0, 0, 0, '0, 0, 0, 4'h0, '0, 1, 8'h13, "R9");
    outEn = 1;
    #0.5;
    check(dataOutEn === 1'b1, "R9", {31'd0, dataOutEn}, 32'd1, "async enable");
    check(dataOut === shadow[8'h13], "R9", dataOut, shadow[8'h13], "async data");
    outEn = 0;
    #0.2;
    check(dataOutEn === 1'b0, "R9", {31'd0, dataOutEn}, 32'd0, "async disable");
    outEn = 1;
    desel(0);

    // R10: sleep releases the bus, ignores inputs, freezes the burst
    op(1, 0, 0, 8'h31, 1, 0, 4'h0, 32'h0C0C_0C0C, 1, 8'h31, "R10");
    op(1, 0, 0, 8'h30, 1, 0, 4'h0, 32'h0A0A_0A0A, 1, 8'h30, "R10");
    op(0, 1, 0, 8'h30, 0, 0, 4'h0, '0, 1, 8'h30, "R10");
    op(0, 0, 0, '0, 0, 0, 4'h0, '0, 1, 8'h30, "R10");
    sleep = 1;
    #0.5;
    check(dataOutEn === 1'b0, "R10", {31'd0, dataOutEn}, 32'd0, "async sleep release");
    for (int n = 0; n < 3; n++)
      op(1, 0, 1, 8'h30, 1, 0, 4'h0, 32'hBEEF_BEEF, 0, '0, "R10");
    sleep = 0;
    op(0, 0, 1, '0, 0, 0, 4'h0, '0, 1, linA(8'h30, 1), "R10");
    op(1, 0, 0, 8'h30, 0, 0, 4'h0, '0, 1, 8'h30, "R10");
    desel(0);

    repeat (3) op(0, 0, 0, '0, 0, 0, 4'h0, '0, 0, '0, "R2");
    check(q.size() == 0, "R2", q.size(), 0, "pending reads");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule